// File: doc/BRIEF.md
# CAN Fault Confinement State Monitor

This block sits beside a CAN controller's error counters and turns their values into one of four fault-confinement states: `ACTIVE`, `WARNING`, `PASSIVE` and `BUSOFF`. It raises a status flag for every change of state, in both directions and for jumps over a state. Each flag has its own interrupt enable, so software learns of every change without polling the counters. Detected bus errors are kept as six sticky type bits behind one shared interrupt enable. An adaptive option turns that error interrupt on only while the node is away from `ACTIVE`, so that a disconnected bus cannot flood the processor.

Once in `BUSOFF`, the state no longer follows the counters. The node leaves `BUSOFF` only through recovery, which counts idle sequences of eleven recessive bits reported by the bit engine. In automatic mode, counting starts as soon as bus-off is entered. In manual mode, counting starts only after software writes a restart request. When recovery completes, the block pulses `cnt_clr` so that the external counters return to zero.

The named transitions are A2W, W2A, W2P, P2W, P2B, B2A, A2P, P2A, A2B and W2B. They are driven by one registered state machine, with a register file on a simple write-strobe and combinational-read interface.

Top module: `fcm_monitor`

## Requirements
- R1: After reset the state code is 00, all status bits are 0, `irq` and `cnt_clr` are 0, and CTRL (address 0) reads 1, meaning automatic recovery is on and all other bits are 0.
- R2: Outside bus-off, the state follows the counters. It is BUSOFF when tx > 255. Otherwise it is PASSIVE when either counter is >= 128. Otherwise it is WARNING when either counter is > 96. Otherwise it is ACTIVE. The state codes are ACTIVE=00, WARNING=01, PASSIVE=10, BUSOFF=11.
- R3: Each state change sets exactly one bit in TSTAT (address 2), and a jump over a state sets only the bit of the jump itself. The bit positions are A2W=0, W2A=1, W2P=2, P2W=3, P2B=4, B2A=5, A2P=6, P2A=7, A2B=8, W2B=9.
- R4: TSTAT and ESTAT bits are sticky and are cleared only by writing 1 to them.
- R5: `irq` includes the OR of TSTAT AND TIEN, where TIEN is at address 1 and uses the same bit positions as TSTAT.
- R6: A `berr_valid` pulse with `berr_kind` 0 to 5 sets ESTAT (address 3) bit `berr_kind`. Kinds 6 and 7 are ignored.
- R7: A pending ESTAT bit drives `irq` when CTRL bit 2 (manual error enable) is 1, or when CTRL bit 1 (adaptive) is 1 and the state is not ACTIVE.
- R8: In BUSOFF, the state stays BUSOFF whatever the counters show, until recovery completes.
- R9: With CTRL bit 0 = 1, the 128th `idle_seq` pulse counted in BUSOFF moves the state to ACTIVE (B2A). At the same time, `cnt_clr` is high for exactly one cycle, and the counters are ignored on the following edge.
- R10: With CTRL bit 0 = 0, `idle_seq` pulses count only after a write of CTRL with bit 3 = 1 made during BUSOFF. A restart write made outside BUSOFF has no effect.
- R11: Address 4 reads the 2-bit state code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| berr_valid | input | 1 | One-cycle pulse per detected bus error |
| berr_kind | input | 3 | Bus error type code, 0 to 5 |
| idle_seq | input | 1 | Pulse per observed run of 11 recessive bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from `reg_addr` |
| fc_state | output | 2 | Current state code |
| cnt_clr | output | 1 | One-cycle request to zero the error counters |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- BUSOFF is held until recovery finishes.
- BUSOFF exits only to ACTIVE.
- `cnt_clr` follows a bus-off exit and freezes the state for one edge.
- Status bits stay set unless a write clears them.
- The recovery count stays within its bound.
- The adaptive gate keeps `irq` low in ACTIVE.

Only the bench scenarios can show the rest: the exact threshold boundaries (96 versus 97, 127 versus 128, 255 versus 256), the flag chosen for each direct jump, and the exact pulse count of 128 in both recovery modes. The same applies to restart pulses being ignored before arming, and to the interplay of masks with pending flags.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_WARN    = 2'b01,
        FC_PASSIVE = 2'b10,
        FC_BUSOFF  = 2'b11
    } fc_state_t;

    localparam int TR_NUM    = 10;
    localparam int TR_A2W    = 0;
    localparam int TR_W2A    = 1;
    localparam int TR_W2P    = 2;
    localparam int TR_P2W    = 3;
    localparam int TR_P2B    = 4;
    localparam int TR_B2A    = 5;
    localparam int TR_A2P    = 6;
    localparam int TR_P2A    = 7;
    localparam int TR_A2B    = 8;
    localparam int TR_W2B    = 9;

    localparam int ERR_KINDS = 6;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_TIEN  = 3'd1;
    localparam logic [2:0] RA_TSTAT = 3'd2;
    localparam logic [2:0] RA_ESTAT = 3'd3;
    localparam logic [2:0] RA_STATE = 3'd4;

endpackage

// File: rtl/fcm_classify.sv
module fcm_classify
    import fcm_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int WARN_LIMIT = 96,
    parameter int PASS_LIMIT = 128,
    parameter int BOFF_LIMIT = 255
) (
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output fc_state_t        level
);

    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIMIT);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIMIT);
    localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIMIT);

    always_comb begin
        if (tec > BOFF_V)
            level = FC_BUSOFF;
        else if (tec >= PASS_V || rec >= PASS_V)
            level = FC_PASSIVE;
        else if (tec > WARN_V || rec > WARN_V)
            level = FC_WARN;
        else
            level = FC_ACTIVE;
    end

endmodule

// File: rtl/fcm_recovery.sv
module fcm_recovery #(
    parameter int RECOV_SEQ = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic counting,
    input  logic idle_pulse,
    output logic done
);

    localparam int CW = $clog2(RECOV_SEQ + 1);
    localparam logic [CW-1:0] LAST = CW'(RECOV_SEQ - 1);

    logic [CW-1:0] seen;

    assign done = counting && idle_pulse && (seen == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !counting)
            seen <= '0;
        else if (idle_pulse)
            seen <= (seen == LAST) ? '0 : seen + 1'b1;
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= LAST);

    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !counting |=> seen == '0);

endmodule

// File: rtl/fcm_regs.sv
module fcm_regs
    import fcm_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [TR_NUM-1:0] tr_pulse,
    input  logic              berr_valid,
    input  logic [2:0]        berr_kind,
    input  fc_state_t         state,
    output logic              auto_recov,
    output logic              restart_req,
    output logic              irq
);

    logic                 adaptive;
    logic                 berr_ie;
    logic [TR_NUM-1:0]    tien;
    logic [TR_NUM-1:0]    tstat;
    logic [ERR_KINDS-1:0] estat;
    logic [ERR_KINDS-1:0] err_set;
    logic [TR_NUM-1:0]    tclr;
    logic [ERR_KINDS-1:0] eclr;
    logic                 berr_en;
    logic                 unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:TR_NUM];

    for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
        assign err_set[k] = berr_valid && (berr_kind == 3'(k));
    end

    assign tclr        = (reg_wr && reg_addr == RA_TSTAT) ? reg_wdata[TR_NUM-1:0]    : '0;
    assign eclr        = (reg_wr && reg_addr == RA_ESTAT) ? reg_wdata[ERR_KINDS-1:0] : '0;
    assign restart_req = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_recov <= 1'b1;
            adaptive   <= 1'b0;
            berr_ie    <= 1'b0;
            tien       <= '0;
            tstat      <= '0;
            estat      <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) begin
                auto_recov <= reg_wdata[0];
                adaptive   <= reg_wdata[1];
                berr_ie    <= reg_wdata[2];
            end
            if (reg_wr && reg_addr == RA_TIEN)
                tien <= reg_wdata[TR_NUM-1:0];
            tstat <= (tstat & ~tclr) | tr_pulse;
            estat <= (estat & ~eclr) | err_set;
        end
    end

    assign berr_en = berr_ie || (adaptive && state != FC_ACTIVE);
    assign irq     = (|(tstat & tien)) || (berr_en && (|estat));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata[2:0]           = {berr_ie, adaptive, auto_recov};
            RA_TIEN:  reg_rdata[TR_NUM-1:0]    = tien;
            RA_TSTAT: reg_rdata[TR_NUM-1:0]    = tstat;
            RA_ESTAT: reg_rdata[ERR_KINDS-1:0] = estat;
            RA_STATE: reg_rdata[1:0]           = state;
            default:  reg_rdata                = '0;
        endcase
    end

    a_r4_tstat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == RA_TSTAT) |=> ((tstat & $past(tstat)) == $past(tstat)));

    a_r4_estat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == RA_ESTAT) |=> ((estat & $past(estat)) == $past(estat)));

    a_r7_adaptive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FC_ACTIVE && !berr_ie && ((tstat & tien) == '0)) |-> !irq);

endmodule

// File: rtl/fcm_monitor.sv
module fcm_monitor
    import fcm_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int WARN_LIMIT = 96,
    parameter int PASS_LIMIT = 128,
    parameter int BOFF_LIMIT = 255,
    parameter int RECOV_SEQ  = 128,
    parameter int REG_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             berr_valid,
    input  logic [2:0]       berr_kind,
    input  logic             idle_seq,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [1:0]       fc_state,
    output logic             cnt_clr,
    output logic             irq
);

    fc_state_t         cur, nxt, level;
    logic [TR_NUM-1:0] tr_pulse;
    logic              auto_recov, restart_req, restart_armed;
    logic              counting, recov_done;

    fcm_classify #(
        .CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT),
        .PASS_LIMIT(PASS_LIMIT), .BOFF_LIMIT(BOFF_LIMIT)
    ) u_classify (
        .tec(tx_err_cnt), .rec(rx_err_cnt), .level(level)
    );

    assign counting = (cur == FC_BUSOFF) && (auto_recov || restart_armed);

    fcm_recovery #(.RECOV_SEQ(RECOV_SEQ)) u_recovery (
        .clk(clk), .rst_n(rst_n), .counting(counting),
        .idle_pulse(idle_seq), .done(recov_done)
    );

    fcm_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_pulse(tr_pulse),
        .berr_valid(berr_valid), .berr_kind(berr_kind), .state(cur),
        .auto_recov(auto_recov), .restart_req(restart_req), .irq(irq)
    );

    always_comb begin
        unique case (cur)
            FC_ACTIVE, FC_WARN, FC_PASSIVE: nxt = cnt_clr ? cur : level;
            FC_BUSOFF:                      nxt = recov_done ? FC_ACTIVE : FC_BUSOFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur           <= FC_ACTIVE;
            cnt_clr       <= 1'b0;
            restart_armed <= 1'b0;
        end else begin
            cur           <= nxt;
            cnt_clr       <= (cur == FC_BUSOFF) && (nxt == FC_ACTIVE);
            restart_armed <= (nxt == FC_BUSOFF) &&
                             (restart_armed || (cur == FC_BUSOFF && restart_req));
        end
    end

    always_comb begin
        tr_pulse = '0;
        case ({cur, nxt})
            {FC_ACTIVE,  FC_WARN}:    tr_pulse[TR_A2W] = 1'b1;
            {FC_WARN,    FC_ACTIVE}:  tr_pulse[TR_W2A] = 1'b1;
            {FC_WARN,    FC_PASSIVE}: tr_pulse[TR_W2P] = 1'b1;
            {FC_PASSIVE, FC_WARN}:    tr_pulse[TR_P2W] = 1'b1;
            {FC_PASSIVE, FC_BUSOFF}:  tr_pulse[TR_P2B] = 1'b1;
            {FC_BUSOFF,  FC_ACTIVE}:  tr_pulse[TR_B2A] = 1'b1;
            {FC_ACTIVE,  FC_PASSIVE}: tr_pulse[TR_A2P] = 1'b1;
            {FC_PASSIVE, FC_ACTIVE}:  tr_pulse[TR_P2A] = 1'b1;
            {FC_ACTIVE,  FC_BUSOFF}:  tr_pulse[TR_A2B] = 1'b1;
            {FC_WARN,    FC_BUSOFF}:  tr_pulse[TR_W2B] = 1'b1;
            default:                  tr_pulse = '0;
        endcase
    end

    assign fc_state = cur;

    a_r8_boff_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == FC_BUSOFF && !recov_done) |=> cur == FC_BUSOFF);

    a_r8_boff_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == FC_BUSOFF && recov_done) |=> cur == FC_ACTIVE);

    a_r9_clr_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |-> (cur == FC_ACTIVE && $past(cur) == FC_BUSOFF));

    a_r9_clr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cur == FC_ACTIVE && !cnt_clr));

    a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tr_pulse));

endmodule

// File: tb/fcm_monitor_test.sv
module fcm_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    // entry: [23:15] tx, [14:6] rx, [5:4] expected state, [3:0] flag index (15 = none)
    localparam logic [23:0] VEC [NV] = '{
        {9'd50,  9'd0,   2'd0, 4'd15},
        {9'd97,  9'd0,   2'd1, 4'd0},
        {9'd96,  9'd0,   2'd0, 4'd1},
        {9'd0,   9'd97,  2'd1, 4'd0},
        {9'd0,   9'd128, 2'd2, 4'd2},
        {9'd0,   9'd127, 2'd1, 4'd3},
        {9'd0,   9'd10,  2'd0, 4'd1},
        {9'd130, 9'd0,   2'd2, 4'd6},
        {9'd20,  9'd20,  2'd0, 4'd7},
        {9'd200, 9'd0,   2'd2, 4'd6},
        {9'd256, 9'd0,   2'd3, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  tx_err_cnt, rx_err_cnt;
    logic        berr_valid, idle_seq, reg_wr;
    logic [2:0]  berr_kind, reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [1:0]  fc_state;
    logic        cnt_clr, irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv;

    fcm_monitor uut (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .berr_valid(berr_valid), .berr_kind(berr_kind), .idle_seq(idle_seq),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fc_state(fc_state), .cnt_clr(cnt_clr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            idle_seq = 1'b1;
            tick();
        end
        idle_seq = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tx_err_cnt = '0; rx_err_cnt = '0; berr_valid = 1'b0;
        berr_kind = '0; idle_seq = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 state", fc_state, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cnt_clr", cnt_clr, 0);
        rd(3'd0, rv); chk("R1 ctrl", rv, 16'h1);
        rd(3'd2, rv); chk("R1 tstat", rv, 0);
        rd(3'd3, rv); chk("R1 estat", rv, 0);

        wr(3'd1, 16'h3FF);

        // R2 R3 R5 table walk
        for (int i = 0; i < NV; i++) begin
            tx_err_cnt = VEC[i][23:15];
            rx_err_cnt = VEC[i][14:6];
            tick();
            chk("R2 state", fc_state, VEC[i][5:4]);
            rd(3'd2, rv);
            chk("R3 flag", rv, (VEC[i][3:0] == 4'd15) ? 16'h0 : (16'h1 << VEC[i][3:0]));
            chk("R5 irq", irq, VEC[i][3:0] != 4'd15);
            wr(3'd2, 16'h3FF);
            rd(3'd2, rv); chk("R4 w1c", rv, 0);
        end

        // R8 counters drop, bus-off held
        tx_err_cnt = 0; rx_err_cnt = 0;
        repeat (3) tick();
        chk("R8 held", fc_state, 3);
        rd(3'd2, rv); chk("R8 no flag", rv, 0);

        // R9 automatic recovery
        idle_pulses(127);
        chk("R9 127 pulses", fc_state, 3);
        idle_pulses(1);
        chk("R9 recovered", fc_state, 0);
        chk("R9 cnt_clr", cnt_clr, 1);
        rd(3'd2, rv); chk("R3 b2a", rv, 16'h20);
        tx_err_cnt = 300;
        tick();
        chk("R9 freeze", fc_state, 0);
        chk("R9 pulse ends", cnt_clr, 0);
        tx_err_cnt = 0;
        tick();
        wr(3'd2, 16'h3FF);

        // R10 manual restart
        wr(3'd0, 16'h8);            // restart outside bus-off, auto off
        tx_err_cnt = 300;
        tick();
        chk("R3 a2b state", fc_state, 3);
        rd(3'd2, rv); chk("R3 a2b", rv, 16'h100);
        wr(3'd2, 16'h3FF);
        tx_err_cnt = 0;
        idle_pulses(130);
        chk("R10 unarmed", fc_state, 3);
        wr(3'd0, 16'h8);
        idle_pulses(127);
        chk("R10 armed 127", fc_state, 3);
        idle_pulses(1);
        chk("R10 recovered", fc_state, 0);
        chk("R10 cnt_clr", cnt_clr, 1);
        tick();
        wr(3'd2, 16'h3FF);

        // R3 W2B
        tx_err_cnt = 100;
        tick();
        chk("R2 warn", fc_state, 1);
        wr(3'd2, 16'h3FF);
        tx_err_cnt = 256;
        tick();
        rd(3'd2, rv); chk("R3 w2b", rv, 16'h200);
        tx_err_cnt = 0;
        wr(3'd0, 16'h8);
        idle_pulses(128);
        chk("R10 second", fc_state, 0);
        tick();

        // R5 R6 R7 bus errors with transitions masked
        wr(3'd1, 16'h0);
        wr(3'd2, 16'h3FF);
        berr_valid = 1'b1; berr_kind = 3'd2;
        tick();
        berr_valid = 1'b0;
        rd(3'd3, rv); chk("R6 kind2", rv, 16'h4);
        chk("R7 gated", irq, 0);
        berr_valid = 1'b1; berr_kind = 3'd6;
        tick();
        berr_valid = 1'b0;
        rd(3'd3, rv); chk("R6 kind6 ignored", rv, 16'h4);
        wr(3'd0, 16'h2);
        chk("R7 adaptive active", irq, 0);
        tx_err_cnt = 100;
        tick();
        rd(3'd4, rv); chk("R11 state reg", rv, 16'h1);
        chk("R7 adaptive warn", irq, 1);
        tx_err_cnt = 0;
        tick();
        chk("R7 adaptive back", irq, 0);
        rd(3'd2, rv); chk("R5 masked flags", rv, 16'h3);
        wr(3'd0, 16'h4);
        chk("R7 manual enable", irq, 1);
        wr(3'd3, 16'h3F);
        rd(3'd3, rv); chk("R4 estat w1c", rv, 0);
        chk("R7 cleared", irq, 0);
        rd(3'd4, rv); chk("R11 active", rv, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule